// File: doc/BRIEF.md
# Peripheral Request Channel Mapper

This block sits between a set of peripheral request wires and a multi-channel DMA engine. Each peripheral request line owns one map register. The register holds an enable flag and the number of the channel that line should wake. Software programs these registers over a small register bus. A write-enable strobe captures data on the clock edge. The read data follows the address combinationally.

The block merges every enabled request that points at the same channel into one pending bit per channel. From the channels that are both pending and marked running by the engine, it picks one and drives a one-hot grant. Channels fall into three fixed priority levels by index. The most urgent non-empty level wins, and a separate rotating pointer per level shares the grant among that level's channels. A grant stays put until the engine reports the end of the burst. The next grant can appear one cycle after the release.

Top module: `dreq_chan_router`

## Requirements
- R1: Map register for requester n sits at byte address 0x100 + 4·n (n < NUM_REQ). A write with the strobe high stores bit 7 (enable) and bits 4:0 (channel number). A read returns those two fields in place and zero in every other bit.
- R2: After reset every map register reads zero, no channel is pending and no grant is driven, whatever the request lines do.
- R3: A requester whose enable bit is 0 never sets any pending bit.
- R4: An enabled requester that is high sets the pending bit of the channel in its channel field. Several enabled requesters aimed at one channel combine by OR.
- R5: Channel c has level min((c mod 16) / 4, 2), where 0 is the most urgent and 2 the least. An eligible channel at a more urgent level always beats one at a less urgent level.
- R6: Within a level, the search starts just after that level's most recently granted channel and wraps around. After reset, each level's search starts at channel 0.
- R7: A channel whose running input is low is never granted, even when pending.
- R8: The grant is one-hot or zero. Once driven, it stays unchanged until burst_done is sampled high, and it is zero on the following cycle.
- R9: With no grant held, a grant to an eligible channel appears on the clock edge after eligibility. With nothing eligible, the grant stays zero.
- R10: Writes to addresses that are not word-aligned, below 0x100, or past the last requester change no map register. Reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| periph_req | input | NUM_REQ | Peripheral request lines |
| ch_run | input | NUM_CH | Per-channel running flags from the engine |
| burst_done | input | 1 | Engine reports end of the granted burst |
| ch_pend | output | NUM_CH | Per-channel pending requests |
| grant | output | NUM_CH | One-hot grant to the winning channel |

## Verification
The bench builds the block with its defaults: 64 requesters, 32 channels and a 12-bit address. At these values the last requester, at 0x1FC, and the highest channel, 31, can both be reached. The address one past the table, 0x200, decodes as out of range. All three priority levels also have several members in both halves of the channel range, so wrap-around inside a level (for example 17 back to 0) and the 4–7 / 20–23 and 8–15 / 24–31 splits are all exercised.

// File: rtl/dreq_chan_router.sv
module dreq_chan_router #(
  parameter int NUM_REQ  = 64,
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 12,
  parameter int MAP_BASE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic [NUM_CH-1:0] ch_run,
  input  logic              burst_done,
  output logic [NUM_CH-1:0] ch_pend,
  output logic [NUM_CH-1:0] grant
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int NLVL = 3;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MAP_BASE);

  function automatic int lvl_of(int c);
    int g;
    g = (c & 15) >> 2;
    return (g > 2) ? 2 : g;
  endfunction

  logic [NUM_REQ-1:0] map_vld;
  logic [CW-1:0]      map_ch [NUM_REQ];
  logic [CW-1:0]      last [NLVL];

  logic [ADDR_W-1:0] off;
  logic [RW-1:0]     idx;
  logic              hit;

  assign off = bus_addr - BASE;
  assign idx = off[RW+1:2];
  assign hit = (bus_addr >= BASE) && (off[1:0] == 2'b00) && (int'(off >> 2) < NUM_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld <= '0;
      for (int n = 0; n < NUM_REQ; n++) map_ch[n] <= '0;
    end else if (bus_wen && hit) begin
      map_vld[idx] <= bus_wdata[7];
      map_ch[idx]  <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[7]      = map_vld[idx];
      bus_rdata[CW-1:0] = map_ch[idx];
    end
  end

  always_comb begin
    ch_pend = '0;
    for (int n = 0; n < NUM_REQ; n++)
      if (map_vld[n] && periph_req[n] && int'(map_ch[n]) < NUM_CH)
        ch_pend[map_ch[n]] = 1'b1;
  end

  logic [NUM_CH-1:0] elig;
  logic              pick_vld;
  logic [CW-1:0]     pick;
  logic [1:0]        pick_lvl;

  assign elig = ch_pend & ch_run;

  always_comb begin
    pick_vld = 1'b0;
    pick     = '0;
    pick_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      for (int k = 1; k <= NUM_CH; k++) begin
        int c;
        c = (int'(last[l]) + k) % NUM_CH;
        if (!pick_vld && elig[c] && lvl_of(c) == l) begin
          pick_vld = 1'b1;
          pick     = CW'(c);
          pick_lvl = 2'(l);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= '0;
      for (int l = 0; l < NLVL; l++) last[l] <= CW'(NUM_CH - 1);
    end else if (|grant) begin
      if (burst_done) grant <= '0;
    end else if (pick_vld) begin
      grant          <= NUM_CH'(1) << pick;
      last[pick_lvl] <= pick;
    end
  end
endmodule

module dreq_chan_router_chk #(
  parameter int NUM_REQ = 64,
  parameter int NUM_CH  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] periph_req,
  input logic [NUM_CH-1:0]  ch_run,
  input logic               burst_done,
  input logic [NUM_CH-1:0]  ch_pend,
  input logic [NUM_CH-1:0]  grant
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !burst_done) |=> (grant == $past(grant))); // R8
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && burst_done) |=> (grant == '0)); // R8
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ((grant == '0) || ((grant & $past(ch_pend & ch_run)) != '0))); // R7
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant == '0) && |(ch_pend & ch_run)) |=> |grant); // R9
  AST_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    |ch_pend |-> |periph_req); // R3
endmodule

bind dreq_chan_router dreq_chan_router_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ch_run(ch_run),
  .burst_done(burst_done), .ch_pend(ch_pend), .grant(grant)
);

// File: tb/test_dreq_chan_router.sv
`timescale 1ns/1ps
module test_dreq_chan_router;
  localparam int NR = 64;
  localparam int NC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NR-1:0] periph_req = '0;
  logic [NC-1:0] ch_run = '0;
  logic burst_done = 1'b0;
  logic [NC-1:0] ch_pend;
  logic [NC-1:0] grant;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  logic [NC-1:0] prev_grant = '0;

  always #2.5 clk = ~clk;

  dreq_chan_router i_dreq_chan_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
    .ch_run(ch_run), .burst_done(burst_done), .ch_pend(ch_pend), .grant(grant)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata == e, req, "readback", bus_rdata, e);
  endtask

  task automatic push(input int c);
    exp_q.push_back(c);
  endtask

  // mode 0 keep requests, 1 drop granted channel's request, 2 drop all
  task automatic serve(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [NC-1:0] g;
      int guard;
      guard = 0;
      do begin @(negedge clk); guard++; end while (grant == '0 && guard < 50);
      g = grant;
      chk(g != '0, "R9", "grant arrives", g, 1);
      repeat (2) begin
        @(negedge clk);
        chk(grant == g, "R8", "grant held", grant, g);
      end
      burst_done = 1'b1;
      if (mode == 1) periph_req[NC-1:0] = periph_req[NC-1:0] & ~g;
      if (mode == 2) periph_req = '0;
      @(negedge clk);
      burst_done = 1'b0;
      chk(grant == '0, "R8", "grant released", grant, 0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && grant != '0 && prev_grant == '0) begin
      if (exp_q.size() == 0) chk(1'b0, "R5/R6", "unexpected grant", grant, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(grant == (NC'(1) << e), "R5/R6", "grant order", grant, NC'(1) << e);
      end
    end
    prev_grant = grant;
  end

  initial begin
    #500000;
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd_chk(12'h100, 32'h0, "R2");
    rd_chk(12'h1FC, 32'h0, "R2");
    periph_req = '1;
    ch_run = '1;
    #1;
    chk(ch_pend == '0, "R2", "no pending after reset", ch_pend, 0);
    @(negedge clk);
    chk(grant == '0, "R2", "no grant after reset", grant, 0);
    periph_req = '0;
    ch_run = '0;

    // R1 register access
    wr(12'h114, 32'hFFFF_FF89);
    rd_chk(12'h114, 32'h89, "R1");
    wr(12'h1FC, 32'h9F);
    rd_chk(12'h1FC, 32'h9F, "R1");
    wr(12'h104, 32'h41);
    rd_chk(12'h104, 32'h01, "R1");

    // R10 writes outside the table
    wr(12'h0FC, 32'h81);
    wr(12'h200, 32'h81);
    wr(12'h102, 32'h81);
    rd_chk(12'h100, 32'h0, "R10");
    rd_chk(12'h200, 32'h0, "R10");
    rd_chk(12'h0FC, 32'h0, "R10");
    periph_req[0] = 1'b1;
    #1;
    chk(ch_pend == '0, "R10", "requester 0 still unmapped", ch_pend, 0);
    periph_req = '0;

    // R3 disabled entry
    wr(12'h11C, 32'h02);
    periph_req[7] = 1'b1;
    #1;
    chk(ch_pend == '0, "R3", "disabled entry forwards nothing", ch_pend, 0);
    periph_req = '0;

    // identity map for requesters 0..31, requester 40 also to channel 3
    for (int i = 0; i < NC; i++) wr(12'h100 + 12'(4 * i), 32'h80 | i);
    wr(12'h1A0, 32'h83);

    // R4 forwarding and OR merge
    periph_req[40] = 1'b1;
    #1;
    chk(ch_pend == (NC'(1) << 3), "R4", "requester 40 to channel 3", ch_pend, NC'(1) << 3);
    periph_req[3] = 1'b1;
    #1;
    chk(ch_pend == (NC'(1) << 3), "R4", "two sources merge", ch_pend, NC'(1) << 3);
    periph_req[63] = 1'b1;
    #1;
    chk(ch_pend == ((NC'(1) << 3) | (NC'(1) << 31)), "R4", "top requester to channel 31",
        ch_pend, (NC'(1) << 3) | (NC'(1) << 31));
    @(negedge clk);
    chk(grant == '0, "R7", "no grant while nothing runs", grant, 0);
    periph_req = '0;
    @(negedge clk);

    // R5 levels, R9 latency
    ch_run = '1;
    push(1); push(5); push(9);
    periph_req[1] = 1'b1; periph_req[5] = 1'b1; periph_req[9] = 1'b1;
    @(negedge clk);
    chk(grant == (NC'(1) << 1), "R9", "grant one edge after eligibility", grant, NC'(1) << 1);
    serve(3, 1);

    // R6 rotation within the high level, medium starved (R5)
    push(2); push(17); push(0); push(2);
    periph_req[0] = 1'b1; periph_req[2] = 1'b1; periph_req[17] = 1'b1; periph_req[6] = 1'b1;
    serve(3, 0);
    serve(1, 2);

    // R6 rotation within the low level
    push(12); push(24); push(8);
    periph_req[8] = 1'b1; periph_req[12] = 1'b1; periph_req[24] = 1'b1;
    serve(3, 1);

    // R7 stopped channel skipped
    ch_run = ~NC'(1);
    push(8);
    periph_req[0] = 1'b1; periph_req[8] = 1'b1;
    serve(1, 1);
    repeat (4) @(negedge clk);
    chk(grant == '0, "R7", "stopped channel not granted", grant, 0);
    chk(ch_pend == NC'(1), "R7", "stopped channel still pending", ch_pend, 1);
    ch_run = '1;
    push(0);
    serve(1, 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all expected grants seen", exp_q.size(), 0);
    chk(grant == '0, "R9", "idle with nothing eligible", grant, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule